// File: doc/BRIEF.md
# Memory Operation Ordering Queue

This block holds in-flight memory operations of a processor core in two slot pools, one for loads and one for stores, and tells the core, for every occupied slot, whether that operation may be sent to memory now. Operations are offered one per cycle in program order, each tagged with a two-bit kind and a flag that says whether the load may be assumed not to overlap older stores. The core reports finished loads and stores by queue and slot number; that frees the slot.

Ordering is relaxed: loads may go ahead of older loads, and may go ahead of older stores when their no-overlap flag is set. Stores stay strictly in order behind every older operation. Two barrier kinds hold back younger loads or younger stores. A barrier takes a slot, never issues, and leaves by itself once nothing older remains in either queue. Relative age is kept in an age matrix, so slot reuse needs no sequence counter and never wraps.

Top module: `lsq_order_unit`

## Requirements
- R1: The kind code uses bit 0 to pick the queue (0 load queue, 1 store queue) and bit 1 to mark a barrier, giving 0 load, 1 store, 2 load barrier, 3 store barrier; an accepted operation takes the lowest-numbered free slot of its queue, reported on `alloc_slot` in the same cycle.
- R2: A queue size parameter of 0 gives that queue `MAX_DEPTH` slots.
- R3: A full flag is high exactly when its queue has no free slot; an offer to a full queue is refused and changes nothing.
- R4: A store is ready only when no older operation of any kind is still held in either queue.
- R5: A load is not held back by older loads.
- R6: A load passes an older store only if its no-overlap flag was set when it was offered; otherwise it waits until every older store has completed.
- R7: A load younger than a held load barrier is not ready; a store younger than a held store barrier is not ready.
- R8: A barrier is never ready and is removed one cycle after it becomes the oldest held operation.
- R9: A completion frees the named load or store slot at the next edge; a completion naming a free slot or a barrier is ignored.
- R10: A reused slot counts as younger than every operation already held.
- R11: After reset both queues are empty, neither full flag is set and no slot is ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_valid | input | 1 | An operation is offered this cycle |
| alloc_kind | input | 2 | Kind code of the offered operation (R1) |
| alloc_noalias | input | 1 | Offered load may pass older stores |
| alloc_accept | output | 1 | Offer taken this cycle |
| alloc_slot | output | IDX_W | Slot given to the offered operation |
| lq_full | output | 1 | Load queue has no free slot |
| sq_full | output | 1 | Store queue has no free slot |
| done_valid | input | 1 | A load or store has finished |
| done_store | input | 1 | Finished operation is in the store queue |
| done_slot | input | IDX_W | Slot of the finished operation |
| ld_ready | output | LQ_N | Per load slot: may issue now |
| st_ready | output | SQ_N | Per store slot: may issue now |

## Verification
The bench builds the block with the load queue size set to 0, the store queue size set to 2 and `MAX_DEPTH` of 4. The size of 0 exercises the mapping to the largest depth, so four loads fill the load queue; two store slots let a store and a store barrier fill the store queue and expose refusal on a full queue. The small depths also force slot reuse early, which brings the age rules across reuse into reach.

// File: rtl/lsq_pkg.sv
package lsq_pkg;
   typedef enum logic [1:0] {
      OP_LOAD  = 2'd0,
      OP_STORE = 2'd1,
      OP_LBAR  = 2'd2,
      OP_SBAR  = 2'd3
   } mem_op_e;

   function automatic logic op_to_store_q(input logic [1:0] kind);
      return kind[0];
   endfunction

   function automatic logic op_is_barrier(input logic [1:0] kind);
      return kind[1];
   endfunction
endpackage

// File: rtl/lsq_slot_pool.sv
module lsq_slot_pool #(
   parameter int N     = 4,
   parameter int IDX_W = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             alloc_en,
   input  logic             alloc_barrier,
   input  logic             alloc_noalias,
   input  logic [N-1:0]     free_mask,
   output logic [N-1:0]     live,
   output logic [N-1:0]     barrier,
   output logic [N-1:0]     noalias,
   output logic             has_free,
   output logic [IDX_W-1:0] free_idx,
   output logic [N-1:0]     alloc_onehot
);
   logic [N-1:0] pick;

   always_comb begin
      pick     = '0;
      free_idx = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (!live[i]) begin
            pick     = '0;
            pick[i]  = 1'b1;
            free_idx = IDX_W'(i);
         end
      end
   end

   assign has_free     = ~&live;
   assign alloc_onehot = alloc_en ? pick : '0;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         live    <= '0;
         barrier <= '0;
         noalias <= '0;
      end else begin
         for (int i = 0; i < N; i++) begin
            if (alloc_onehot[i]) begin
               live[i]    <= 1'b1;
               barrier[i] <= alloc_barrier;
               noalias[i] <= alloc_noalias;
            end else if (free_mask[i]) begin
               live[i] <= 1'b0;
            end
         end
      end
   end

   // R1: at most one slot becomes occupied per cycle
   a_r1_single_alloc: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(live & ~$past(live)));
endmodule

// File: rtl/lsq_age_matrix.sv
module lsq_age_matrix #(
   parameter int T = 8
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [T-1:0]        set_mask,
   input  logic [T-1:0]        live,
   output logic [T-1:0][T-1:0] older
);
   for (genvar r = 0; r < T; r++) begin : g_row
      for (genvar c = 0; c < T; c++) begin : g_col
         if (r == c) begin : g_diag
            assign older[r][c] = 1'b0;
         end else begin : g_cell
            always_ff @(posedge clk) begin
               if (!rst_n)           older[r][c] <= 1'b0;
               else if (set_mask[c]) older[r][c] <= live[r];
               else if (set_mask[r]) older[r][c] <= 1'b0;
            end
            if (r < c) begin : g_chk
               // R10: two held operations always have exactly one older
               a_r10_age_antisym: assert property (@(posedge clk) disable iff (!rst_n)
                  (live[r] && live[c]) |-> (older[r][c] != older[c][r]));
            end
         end
      end
   end
endmodule

// File: rtl/lsq_issue_logic.sv
module lsq_issue_logic #(
   parameter int LQ_N = 4,
   parameter int T    = 8
) (
   input  logic [T-1:0]        live,
   input  logic [T-1:0]        barrier,
   input  logic [T-1:0]        noalias,
   input  logic [T-1:0][T-1:0] older,
   output logic [T-1:0]        ready,
   output logic [T-1:0]        retire
);
   logic [T-1:0] lbar_mask, store_mask;

   for (genvar j = 0; j < T; j++) begin : g_mask
      if (j < LQ_N) begin : g_ld
         assign lbar_mask[j]  = live[j] & barrier[j];
         assign store_mask[j] = 1'b0;
      end else begin : g_st
         assign lbar_mask[j]  = 1'b0;
         assign store_mask[j] = live[j] & ~barrier[j];
      end
   end

   for (genvar g = 0; g < T; g++) begin : g_ent
      logic [T-1:0] col;
      logic any_older, any_lbar, any_store;
      for (genvar j = 0; j < T; j++) begin : g_c
         assign col[j] = older[j][g] & live[j];
      end
      assign any_older = |col;
      assign any_lbar  = |(col & lbar_mask);
      assign any_store = |(col & store_mask);
      assign retire[g] = live[g] & barrier[g] & ~any_older;
      if (g < LQ_N) begin : g_load
         assign ready[g] = live[g] & ~barrier[g] & ~any_lbar & (noalias[g] | ~any_store);
      end else begin : g_store
         assign ready[g] = live[g] & ~barrier[g] & ~any_older;
      end
   end
endmodule

// File: rtl/lsq_order_unit.sv
module lsq_order_unit
   import lsq_pkg::*;
#(
   parameter int LQ_SIZE   = 4,
   parameter int SQ_SIZE   = 4,
   parameter int MAX_DEPTH = 8,
   localparam int LQ_N  = (LQ_SIZE == 0) ? MAX_DEPTH : LQ_SIZE,
   localparam int SQ_N  = (SQ_SIZE == 0) ? MAX_DEPTH : SQ_SIZE,
   localparam int IDX_W = (MAX_DEPTH > 1) ? $clog2(MAX_DEPTH) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             alloc_valid,
   input  logic [1:0]       alloc_kind,
   input  logic             alloc_noalias,
   output logic             alloc_accept,
   output logic [IDX_W-1:0] alloc_slot,
   output logic             lq_full,
   output logic             sq_full,
   input  logic             done_valid,
   input  logic             done_store,
   input  logic [IDX_W-1:0] done_slot,
   output logic [LQ_N-1:0]  ld_ready,
   output logic [SQ_N-1:0]  st_ready
);
   localparam int T = LQ_N + SQ_N;

   if (MAX_DEPTH < 1 || LQ_SIZE < 0 || SQ_SIZE < 0 ||
       LQ_SIZE > MAX_DEPTH || SQ_SIZE > MAX_DEPTH) begin : g_bad_param
      $error("lsq_order_unit: queue sizes must lie in 0..MAX_DEPTH");
   end

   logic to_sq, is_bar;
   logic lq_free, sq_free;
   logic [IDX_W-1:0] lq_idx, sq_idx;
   logic [LQ_N-1:0] lq_live, lq_bar, lq_na, lq_set, lq_done;
   logic [SQ_N-1:0] sq_live, sq_bar, sq_na, sq_set, sq_done;
   logic [T-1:0] all_live, all_bar, all_na, all_set, all_ready, all_retire;
   logic [T-1:0][T-1:0] older;

   assign to_sq        = op_to_store_q(alloc_kind);
   assign is_bar       = op_is_barrier(alloc_kind);
   assign alloc_accept = alloc_valid & (to_sq ? sq_free : lq_free);
   assign alloc_slot   = to_sq ? sq_idx : lq_idx;
   assign lq_full      = ~lq_free;
   assign sq_full      = ~sq_free;

   for (genvar i = 0; i < LQ_N; i++) begin : g_ld_done
      assign lq_done[i] = done_valid & ~done_store & (done_slot == IDX_W'(i))
                          & lq_live[i] & ~lq_bar[i];
   end
   for (genvar i = 0; i < SQ_N; i++) begin : g_st_done
      assign sq_done[i] = done_valid & done_store & (done_slot == IDX_W'(i))
                          & sq_live[i] & ~sq_bar[i];
   end

   lsq_slot_pool #(.N(LQ_N), .IDX_W(IDX_W)) u_lq (
      .clk(clk), .rst_n(rst_n),
      .alloc_en(alloc_accept & ~to_sq), .alloc_barrier(is_bar),
      .alloc_noalias(alloc_noalias),
      .free_mask(lq_done | all_retire[LQ_N-1:0]),
      .live(lq_live), .barrier(lq_bar), .noalias(lq_na),
      .has_free(lq_free), .free_idx(lq_idx), .alloc_onehot(lq_set)
   );

   lsq_slot_pool #(.N(SQ_N), .IDX_W(IDX_W)) u_sq (
      .clk(clk), .rst_n(rst_n),
      .alloc_en(alloc_accept & to_sq), .alloc_barrier(is_bar),
      .alloc_noalias(1'b0),
      .free_mask(sq_done | all_retire[T-1:LQ_N]),
      .live(sq_live), .barrier(sq_bar), .noalias(sq_na),
      .has_free(sq_free), .free_idx(sq_idx), .alloc_onehot(sq_set)
   );

   assign all_live = {sq_live, lq_live};
   assign all_bar  = {sq_bar, lq_bar};
   assign all_na   = {sq_na, lq_na};
   assign all_set  = {sq_set, lq_set};

   lsq_age_matrix #(.T(T)) u_age (
      .clk(clk), .rst_n(rst_n),
      .set_mask(all_set), .live(all_live), .older(older)
   );

   lsq_issue_logic #(.LQ_N(LQ_N), .T(T)) u_issue (
      .live(all_live), .barrier(all_bar), .noalias(all_na),
      .older(older), .ready(all_ready), .retire(all_retire)
   );

   assign ld_ready = all_ready[LQ_N-1:0];
   assign st_ready = all_ready[T-1:LQ_N];

   // R8: a barrier slot never reports ready
   a_r8_barrier_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
      ((ld_ready & lq_bar) == '0) && ((st_ready & sq_bar) == '0));

   // R3: an offer to a full queue is refused
   a_r3_full_refuses: assert property (@(posedge clk) disable iff (!rst_n)
      (alloc_valid && ((to_sq && sq_full) || (!to_sq && lq_full))) |-> !alloc_accept);

   // R11: nothing is held, hence nothing ready, in the first cycle after reset
   a_r11_empty_after_reset: assert property (@(posedge clk)
      $rose(rst_n) |-> (ld_ready == '0 && st_ready == '0 && !lq_full && !sq_full));
endmodule

// File: tb/lsq_order_unit_test.sv
module lsq_order_unit_test;
   localparam int LQ_SIZE = 0;
   localparam int SQ_SIZE = 2;
   localparam int MAXD    = 4;
   localparam int LQN     = 4;
   localparam int SQN     = 2;
   localparam int IW      = 2;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic alloc_valid = 1'b0;
   logic [1:0] alloc_kind = 2'd0;
   logic alloc_noalias = 1'b1;
   logic alloc_accept;
   logic [IW-1:0] alloc_slot;
   logic lq_full, sq_full;
   logic done_valid = 1'b0;
   logic done_store = 1'b0;
   logic [IW-1:0] done_slot = '0;
   logic [LQN-1:0] ld_ready;
   logic [SQN-1:0] st_ready;

   int checks = 0;
   int fails  = 0;
   bit ended  = 0;

   always #2 clk = ~clk;

   lsq_order_unit #(.LQ_SIZE(LQ_SIZE), .SQ_SIZE(SQ_SIZE), .MAX_DEPTH(MAXD)) uut (
      .clk(clk), .rst_n(rst_n),
      .alloc_valid(alloc_valid), .alloc_kind(alloc_kind), .alloc_noalias(alloc_noalias),
      .alloc_accept(alloc_accept), .alloc_slot(alloc_slot),
      .lq_full(lq_full), .sq_full(sq_full),
      .done_valid(done_valid), .done_store(done_store), .done_slot(done_slot),
      .ld_ready(ld_ready), .st_ready(st_ready)
   );

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk); #1;
   endtask

   // offer one operation; returns accept and slot seen in the offer cycle
   task automatic offer(input logic [1:0] kind, input logic na,
                        output logic acc, output int slot);
      @(negedge clk);
      alloc_valid = 1'b1; alloc_kind = kind; alloc_noalias = na;
      #1;
      acc = alloc_accept; slot = int'(alloc_slot);
      @(posedge clk); #1;
      alloc_valid = 1'b0; alloc_noalias = 1'b1;
   endtask

   task automatic finish_op(input logic st, input int slot);
      @(negedge clk);
      done_valid = 1'b1; done_store = st; done_slot = IW'(slot);
      @(posedge clk); #1;
      done_valid = 1'b0;
   endtask

   task automatic t_reset();
      chk("R11 ld_ready", int'(ld_ready), 0);
      chk("R11 st_ready", int'(st_ready), 0);
      chk("R11 lq_full", int'(lq_full), 0);
      chk("R11 sq_full", int'(sq_full), 0);
   endtask

   task automatic t_load_vs_store();
      logic a; int s;
      offer(2'd1, 1'b0, a, s);
      chk("R1 store slot", s, 0);
      offer(2'd0, 1'b1, a, s);
      chk("R1 load slot", s, 0);
      offer(2'd0, 1'b0, a, s);
      chk("R1 second load slot", s, 1);
      chk("R6 noalias load passes store", int'(ld_ready[0]), 1);
      chk("R6 aliasing load waits on store", int'(ld_ready[1]), 0);
      chk("R4 oldest store ready", int'(st_ready[0]), 1);
      finish_op(1'b1, 0);
      chk("R6 aliasing load freed by store done", int'(ld_ready[1]), 1);
      finish_op(1'b0, 0);
      finish_op(1'b0, 1);
      chk("R9 queue empty after done", int'(ld_ready), 0);
   endtask

   task automatic t_store_order();
      logic a; int s;
      offer(2'd0, 1'b1, a, s);
      offer(2'd1, 1'b0, a, s);
      offer(2'd1, 1'b0, a, s);
      chk("R4 store waits older load", int'(st_ready), 0);
      chk("R5 load ready", int'(ld_ready[0]), 1);
      finish_op(1'b0, 0);
      chk("R4 first store ready, second waits", int'(st_ready), 1);
      finish_op(1'b1, 0);
      chk("R4 second store ready", int'(st_ready), 2);
      finish_op(1'b1, 1);
   endtask

   task automatic t_loads_and_fill();
      logic a; int s;
      for (int i = 0; i < 3; i++) offer(2'd0, 1'b0, a, s);
      chk("R5 loads pass loads", int'(ld_ready), 7);
      chk("R2 not full at three", int'(lq_full), 0);
      offer(2'd0, 1'b0, a, s);
      chk("R2 fourth load slot", s, 3);
      chk("R2 full at MAX_DEPTH", int'(lq_full), 1);
      offer(2'd0, 1'b0, a, s);
      chk("R3 refused when full", int'(a), 0);
      chk("R3 refusal changes nothing", int'(ld_ready), 15);
      for (int i = 0; i < 4; i++) finish_op(1'b0, i);
      chk("R3 full drops", int'(lq_full), 0);
   endtask

   task automatic t_load_barrier();
      logic a; int s;
      offer(2'd0, 1'b1, a, s);
      offer(2'd2, 1'b1, a, s);
      chk("R1 barrier slot", s, 1);
      offer(2'd0, 1'b1, a, s);
      offer(2'd1, 1'b0, a, s);
      chk("R7 load behind load barrier", int'(ld_ready[2]), 0);
      chk("R8 barrier not ready", int'(ld_ready[1]), 0);
      finish_op(1'b0, 1);
      chk("R9 done on barrier ignored", int'(ld_ready[2]), 0);
      finish_op(1'b0, 0);
      chk("R8 barrier still held this cycle", int'(ld_ready[2]), 0);
      tick();
      chk("R8 barrier removed, load ready", int'(ld_ready[2]), 1);
      chk("R4 store still waits younger-than-load", int'(st_ready[0]), 0);
      finish_op(1'b0, 2);
      chk("R4 store ready once alone", int'(st_ready[0]), 1);
      finish_op(1'b1, 0);
   endtask

   task automatic t_store_barrier();
      logic a; int s;
      offer(2'd1, 1'b0, a, s);
      offer(2'd3, 1'b0, a, s);
      chk("R3 store queue full", int'(sq_full), 1);
      offer(2'd1, 1'b0, a, s);
      chk("R3 store refused", int'(a), 0);
      offer(2'd0, 1'b1, a, s);
      chk("R7 load not held by store barrier", int'(ld_ready[0]), 1);
      finish_op(1'b1, 0);
      tick();
      chk("R8 store barrier removed", int'(sq_full), 0);
      offer(2'd1, 1'b0, a, s);
      chk("R1 store slot reuse lowest", s, 0);
      chk("R4 store behind load", int'(st_ready), 0);
      finish_op(1'b0, 0);
      chk("R7 store ready after barrier gone", int'(st_ready), 1);
      finish_op(1'b1, 0);
   endtask

   task automatic t_reuse_and_ignore();
      logic a; int s;
      finish_op(1'b1, 1);
      chk("R9 done to free slot ignored", int'(sq_full), 0);
      offer(2'd0, 1'b0, a, s);
      offer(2'd0, 1'b0, a, s);
      finish_op(1'b0, 0);
      offer(2'd1, 1'b0, a, s);
      offer(2'd0, 1'b0, a, s);
      chk("R10 reused slot number", s, 0);
      chk("R10 reused slot younger than store", int'(ld_ready[0]), 0);
      chk("R10 older load unaffected", int'(ld_ready[1]), 1);
      chk("R10 store behind older load", int'(st_ready[0]), 0);
      finish_op(1'b0, 1);
      finish_op(1'b1, 0);
      chk("R10 reused load ready", int'(ld_ready[0]), 1);
      finish_op(1'b0, 0);
   endtask

   task automatic report();
      if (!ended) begin
         ended = 1;
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      checks++; fails++;
      $display("FAIL watchdog actual=running expected=finished");
      report();
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      #1;
      t_reset();
      t_load_vs_store();
      t_store_order();
      t_loads_and_fill();
      t_load_barrier();
      t_store_barrier();
      t_reuse_and_ignore();
      report();
   end
endmodule